// File: doc/BRIEF.md
# Auxiliary DAC Level Register with Staged Latch

This block holds the 12-bit level code for an auxiliary DAC in a chip's register space. Software reaches it through a byte-wide register port. The code is split across two byte addresses. The low byte at 0x30 carries code bits 7:0. The byte at 0x31 carries code bits 11:8 in its lower nibble.

Each byte write lands in a staging register. The DAC input comes from a separate active register. The active register is loaded only when the command register decode issues a one-cycle latch pulse. Software can therefore rewrite both halves of the code one byte at a time while the DAC keeps its previous, coherent value. It then commits the new code with a single latch.

Both registers are volatile. Every reset clears them to zero. Reads at either address return the staging contents, so software can confirm a pending code before it latches it.

The address decoder sorts each access into one of three selections:
- `SEL_LO`: the low byte.
- `SEL_HI`: the high nibble.
- `SEL_NONE`: any other address, or no write enable.

The staging register moves between two conditions on every clock:
- Hold, under `SEL_NONE`.
- Byte-merge, under `SEL_LO` or `SEL_HI`.

The active register also has two conditions:
- Keep, when the latch pulse is low.
- Transfer, when it is high.

Top module: `auxdac_level_reg`

## Requirements
- R1: During and after reset, with no later write or latch, `dac_code` is 0. Reads at 0x30 and at 0x31 also return 0.
- R2: A write to address 0x30 replaces staging bits 7:0 with `wr_data`. It leaves staging bits 11:8 unchanged.
- R3: A write to address 0x31 replaces staging bits 11:8 with `wr_data[3:0]`. Bits `wr_data[7:4]` are discarded. A read at 0x31 returns 0 in bits 7:4.
- R4: A read at 0x30 returns staging bits 7:0. A read at 0x31 returns staging bits 11:8 in bits 3:0. Reads never return the active code.
- R5: `dac_code` does not change in any cycle without a latch pulse, whatever bytes are written.
- R6: A latch pulse sampled at a clock edge makes `dac_code` equal to the staging value after that edge.
- R7: If a byte write and a latch pulse fall on the same edge, `dac_code` takes the staging value from before that write. The write still lands in staging.
- R8: Writes to any address other than 0x30 and 0x31 leave staging unchanged. Reads of such addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 8 | Byte address of the write |
| wr_data | input | 8 | Byte written |
| rd_addr | input | 8 | Byte address of the combinational read |
| rd_data | output | 8 | Staging byte at `rd_addr` |
| latch_pulse | input | 1 | One-cycle transfer command from the command register decode |
| dac_code | output | 12 | Code presented to the DAC |

## Verification
The bench sweeps every value of the low byte and every value of the high-data byte, including patterns with the upper nibble set. These sweeps tell a correct byte merge apart from bleed into the other half and from a leaked upper nibble.

A walk over all other byte addresses, with reads and writes, separates a narrow decode from a loose one. Writes with no latch separate read-back of staging from read-back of the active code, and show that the output holds.

Latch pulses are applied in three ways: alone, in the same cycle as a low or high write, and back to back. This separates pre-write capture from post-write capture.

// File: rtl/auxdac_level_pkg.sv
package auxdac_level_pkg;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_LO   = 2'd1,
        SEL_HI   = 2'd2
    } byte_sel_e;

endpackage

// File: rtl/auxdac_byte_decode.sv
module auxdac_byte_decode
    import auxdac_level_pkg::*;
#(
    parameter int          ADDR_W  = 8,
    parameter logic [7:0]  LO_ADDR = 8'h30,
    parameter logic [7:0]  HI_ADDR = 8'h31
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output byte_sel_e         sel
);

    always_comb begin
        sel = SEL_NONE;
        if (en) begin
            if (addr == ADDR_W'(LO_ADDR)) begin
                sel = SEL_LO;
            end else if (addr == ADDR_W'(HI_ADDR)) begin
                sel = SEL_HI;
            end
        end
    end

endmodule

// File: rtl/auxdac_stage_reg.sv
module auxdac_stage_reg
    import auxdac_level_pkg::*;
#(
    parameter int CODE_W = 12,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  byte_sel_e         wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    input  byte_sel_e         rd_sel,
    output logic [BYTE_W-1:0] rd_data,
    output logic [CODE_W-1:0] stage_q
);

    localparam int HI_W = CODE_W - BYTE_W;

    logic [CODE_W-1:0] stage_d;
    logic [BYTE_W-1:0] hi_byte;

    // Byte-merge: only the selected half of the staging code is replaced.
    always_comb begin
        stage_d = stage_q;
        unique case (wr_sel)
            SEL_LO:   stage_d[BYTE_W-1:0]      = wr_data;
            SEL_HI:   stage_d[CODE_W-1:BYTE_W] = wr_data[HI_W-1:0];
            default:  stage_d                  = stage_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    // Unused upper bits of the high byte read as zero.
    always_comb begin
        hi_byte            = '0;
        hi_byte[HI_W-1:0]  = stage_q[CODE_W-1:BYTE_W];
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_sel)
            SEL_LO:   rd_data = stage_q[BYTE_W-1:0];
            SEL_HI:   rd_data = hi_byte;
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/auxdac_active_reg.sv
module auxdac_active_reg #(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latch_pulse,
    input  logic [CODE_W-1:0] stage_q,
    output logic [CODE_W-1:0] active_q
);

    // Transfer samples the staging value present before this edge's write.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= '0;
        end else if (latch_pulse) begin
            active_q <= stage_q;
        end
    end

endmodule

// File: rtl/auxdac_level_reg.sv
module auxdac_level_reg
    import auxdac_level_pkg::*;
#(
    parameter int          CODE_W  = 12,
    parameter int          ADDR_W  = 8,
    parameter logic [7:0]  LO_ADDR = 8'h30,
    parameter logic [7:0]  HI_ADDR = 8'h31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    input  logic              latch_pulse,
    output logic [CODE_W-1:0] dac_code
);

    localparam int BYTE_W = 8;

    byte_sel_e         wr_sel;
    byte_sel_e         rd_sel;
    logic [CODE_W-1:0] stage_q;

    auxdac_byte_decode #(
        .ADDR_W (ADDR_W),
        .LO_ADDR(LO_ADDR),
        .HI_ADDR(HI_ADDR)
    ) i_wr_decode (
        .en  (wr_en),
        .addr(wr_addr),
        .sel (wr_sel)
    );

    auxdac_byte_decode #(
        .ADDR_W (ADDR_W),
        .LO_ADDR(LO_ADDR),
        .HI_ADDR(HI_ADDR)
    ) i_rd_decode (
        .en  (1'b1),
        .addr(rd_addr),
        .sel (rd_sel)
    );

    auxdac_stage_reg #(
        .CODE_W(CODE_W),
        .BYTE_W(BYTE_W)
    ) i_stage (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_sel (wr_sel),
        .wr_data(wr_data),
        .rd_sel (rd_sel),
        .rd_data(rd_data),
        .stage_q(stage_q)
    );

    auxdac_active_reg #(
        .CODE_W(CODE_W)
    ) i_active (
        .clk        (clk),
        .rst_n      (rst_n),
        .latch_pulse(latch_pulse),
        .stage_q    (stage_q),
        .active_q   (dac_code)
    );

endmodule

// File: rtl/auxdac_level_chk.sv
module auxdac_level_chk #(
    parameter int          CODE_W  = 12,
    parameter int          ADDR_W  = 8,
    parameter logic [7:0]  LO_ADDR = 8'h30,
    parameter logic [7:0]  HI_ADDR = 8'h31
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        wr_data,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [7:0]        rd_data,
    input logic              latch_pulse,
    input logic [CODE_W-1:0] dac_code,
    input logic [CODE_W-1:0] stage_q
);

    localparam int HI_W = CODE_W - 8;

    // R2
    a_r2_low_merge: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(LO_ADDR)) |=> (stage_q[7:0] == $past(wr_data)));

    // R3
    a_r3_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ADDR_W'(HI_ADDR)) |-> ((rd_data >> HI_W) == 8'd0));

    // R5
    a_r5_hold_code: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_pulse |=> $stable(dac_code));

    // R6, R7
    a_r6_transfer: assert property (@(posedge clk) disable iff (!rst_n)
        latch_pulse |=> (dac_code == $past(stage_q)));

    // R8
    a_r8_foreign_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != ADDR_W'(LO_ADDR) && wr_addr != ADDR_W'(HI_ADDR))
        |=> $stable(stage_q));

endmodule

bind auxdac_level_reg auxdac_level_chk #(
    .CODE_W (CODE_W),
    .ADDR_W (ADDR_W),
    .LO_ADDR(LO_ADDR),
    .HI_ADDR(HI_ADDR)
) i_level_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .latch_pulse(latch_pulse),
    .dac_code   (dac_code),
    .stage_q    (stage_q)
);

// File: tb/test_auxdac_level_reg.sv
`timescale 1ns/1ps
module test_auxdac_level_reg;

    localparam logic [7:0] LO = 8'h30;
    localparam logic [7:0] HI = 8'h31;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        latch_pulse = 1'b0;
    logic [11:0] dac_code;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [11:0] m_stage = '0;
    logic [11:0] m_act   = '0;

    always #2 clk = ~clk;

    auxdac_level_reg i_auxdac_level_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .latch_pulse(latch_pulse),
        .dac_code   (dac_code)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock with the given stimulus; the model follows R6/R7 ordering.
    task automatic step(input bit we, input logic [7:0] a, input logic [7:0] d, input bit lat);
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d; latch_pulse = lat;
        if (lat) m_act = m_stage;
        if (we && a == LO) m_stage[7:0] = d;
        if (we && a == HI) m_stage[11:8] = d[3:0];
        @(negedge clk);
        wr_en = 1'b0; latch_pulse = 1'b0;
    endtask

    task automatic read_chk(input string req, input logic [7:0] a);
        logic [7:0] e;
        rd_addr = a;
        #0.5;
        if (a == LO)      e = m_stage[7:0];
        else if (a == HI) e = {4'h0, m_stage[11:8]};
        else              e = 8'h00;
        chk(req, {8'h0, rd_data}, {8'h0, e});
    endtask

    task automatic code_chk(input string req);
        chk(req, {4'h0, dac_code}, {4'h0, m_act});
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        code_chk("R1 code in reset");
        read_chk("R1 low in reset", LO);
        read_chk("R1 high in reset", HI);
        rst_n = 1'b1;
        @(negedge clk);
        code_chk("R1 code after reset");

        // R2, R4, R5: sweep low byte, no latch
        for (int v = 0; v < 256; v++) begin
            step(1'b1, LO, 8'(v), 1'b0);
            read_chk("R2 R4 low byte", LO);
            read_chk("R2 high untouched", HI);
            code_chk("R5 hold during low write");
        end

        // R3, R4, R5: sweep high byte including upper nibble
        for (int v = 0; v < 256; v++) begin
            step(1'b1, HI, 8'(v), 1'b0);
            read_chk("R3 R4 high nibble", HI);
            read_chk("R3 low untouched", LO);
            code_chk("R5 hold during high write");
        end

        // R6: plain latch, then read-back still staging (R4)
        step(1'b1, LO, 8'hA5, 1'b0);
        step(1'b1, HI, 8'hF3, 1'b0);
        code_chk("R5 before latch");
        step(1'b0, 8'h00, 8'h00, 1'b1);
        code_chk("R6 latch transfer");
        step(1'b1, LO, 8'h11, 1'b0);
        read_chk("R4 read returns staging", LO);
        code_chk("R5 active kept");

        // R7: write and latch on the same edge
        step(1'b1, HI, 8'h07, 1'b1);
        code_chk("R7 pre-write capture high");
        read_chk("R7 write still lands", HI);
        step(1'b1, LO, 8'hC8, 1'b1);
        code_chk("R7 pre-write capture low");
        read_chk("R7 low write lands", LO);
        step(1'b0, 8'h00, 8'h00, 1'b1);
        code_chk("R6 back-to-back latch");

        // R8: every foreign address, write then read-back
        for (int a = 0; a < 256; a++) begin
            if (8'(a) != LO && 8'(a) != HI) begin
                step(1'b1, 8'(a), 8'(~a), 1'b0);
                read_chk("R8 foreign read", 8'(a));
                read_chk("R8 low unchanged", LO);
                read_chk("R8 high unchanged", HI);
            end
        end
        step(1'b0, 8'h00, 8'h00, 1'b1);
        code_chk("R8 R6 latch after foreign writes");

        // R1: reset again clears both registers
        @(negedge clk);
        rst_n = 1'b0;
        m_stage = '0;
        m_act = '0;
        @(negedge clk);
        code_chk("R1 code after second reset");
        read_chk("R1 low after second reset", LO);
        read_chk("R1 high after second reset", HI);
        rst_n = 1'b1;
        step(1'b0, 8'h00, 8'h00, 1'b1);
        code_chk("R1 latch of cleared staging");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule